// File: doc/BRIEF.md
# Critical-Word-First Cache Line Fill Sequencer

This block refills one 32-byte cache line after a miss. The cache controller hands it the missing address, the way that will receive the line and a bus-width mode. The sequencer then takes burst beats from a simple data bus (one beat per cycle that `bus_valid` is high) and turns each beat into a write into the chosen way. The burst starts at the double word that holds the missed address and then wraps in ascending order around the line.

The bus is either 64 bits wide, which gives four beats per line, or 32 bits wide, which gives eight beats per line. The requester receives the critical double word in the same cycle that it is written into the array. On a 32-bit bus that happens once both halves of the double word have arrived.

While a fill is running, the block holds `busy` high so that the cache refuses internal accesses. After the final write it raises a one-cycle `done` together with a tag-array write for the way. The cache may then resume.

Top module: `lfs_line_fill`

## Requirements
- R1: After reset, `busy`, `wr_en`, `fwd_valid`, `done` and `tag_we` are all 0.
- R2: With `wide_mode`=1 latched at the request, a fill makes exactly four writes with `wr_mask`=2'b11 and `wr_data` equal to the 64-bit beat. The double-word indices run s, s+1, s+2, s+3 modulo 4, where s is `req_addr[4:3]`.
- R3: With `wide_mode`=0 latched, a fill makes exactly eight writes. The 32-bit word indices run 2s, 2s+1, … modulo 8, and `wr_dword` is the word index divided by 2. An even word writes `bus_data[31:0]` into `wr_data[31:0]` with mask 2'b01. An odd word writes it into `wr_data[63:32]` with mask 2'b10. The unused half is zero.
- R4: In 64-bit mode, `fwd_valid` is high only in the cycle of the first write, and `fwd_data` equals that beat.
- R5: In 32-bit mode, `fwd_valid` is high only in the cycle of the second write, and `fwd_data` is {second beat[31:0], first beat[31:0]}.
- R6: A write appears in the cycle after a beat is sampled with `bus_valid` high. A cycle with `bus_valid` low produces no write and does not advance the burst.
- R7: `busy` is high from the cycle after a request is accepted through the `done` cycle. A request is accepted only when `busy` is low, and a request made while busy is ignored.
- R8: `done` is a one-cycle pulse in the cycle after the final write. `tag_we` is high in that same cycle, with `tag_way`, `tag_index` and `tag_value` taken from the request.
- R9: The bus-width mode is latched when the request is accepted. Changes to `wide_mode` during the burst do not alter the beat count, the order or the lanes.
- R10: Every write carries the requested way on `wr_way` and the set index `req_addr[11:5]` on `wr_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request |
| req_addr | input | 29 | Miss address, bits 31:3 (double-word address) |
| req_way | input | 2 | Way that receives the line |
| wide_mode | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus |
| bus_valid | input | 1 | A beat is present on bus_data |
| bus_data | input | 64 | Beat data; bits 31:0 in 32-bit mode |
| busy | output | 1 | Cache blocked for internal accesses |
| wr_en | output | 1 | Data-array write strobe |
| wr_way | output | 2 | Way written |
| wr_index | output | 7 | Set written |
| wr_dword | output | 2 | Double word within the line |
| wr_mask | output | 2 | 32-bit half enables (bit 0 = low half) |
| wr_data | output | 64 | Write data |
| fwd_valid | output | 1 | Critical double word forwarded |
| fwd_data | output | 64 | Forwarded double word |
| done | output | 1 | Fill complete pulse |
| tag_we | output | 1 | Tag/valid commit strobe |
| tag_way | output | 2 | Way committed |
| tag_index | output | 7 | Set committed |
| tag_value | output | 20 | Tag committed (address bits 31:12) |

## Verification
Each write, and the forward that goes with it, is due exactly one cycle after the edge that samples a valid beat. `busy` rises one cycle after the request edge. `done` and the tag commit come one cycle after the last write. The bench keeps a behavioural model that updates on the same edges and sets up the values due in the following cycle. It then compares every output on the falling edge, half a cycle after the registers change, so each result is checked in exactly the cycle it is due. Gaps in `bus_valid`, requests while busy and mode changes mid-burst are mixed into the stimulus, so any early or late result shows up as a mismatch.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    typedef enum logic [1:0] {
        LFS_IDLE   = 2'd0,
        LFS_FILL   = 2'd1,
        LFS_FINISH = 2'd2
    } lfs_state_e;

endpackage

// File: rtl/lfs_beat_order.sv
module lfs_beat_order #(
    parameter  int HW_PER_LINE = 8,
    localparam int HW_W        = $clog2(HW_PER_LINE),
    localparam int DW_W        = HW_W - 1
) (
    input  logic            wide,
    input  logic [DW_W-1:0] start_dw,
    input  logic [HW_W-1:0] cnt,
    output logic [HW_W-1:0] word_idx,
    output logic            last
);
    localparam int DW_PER_LINE = HW_PER_LINE / 2;

    logic [HW_W-1:0] base;
    logic [HW_W-1:0] step;

    always_comb begin
        base = {start_dw, 1'b0};
        // wide beats step by a whole double word, narrow beats by one half
        step = wide ? {cnt[DW_W-1:0], 1'b0} : cnt;
        // power-of-two line: natural overflow performs the wrap
        word_idx = base + step;
        last = wide ? (cnt == HW_W'(DW_PER_LINE - 1))
                    : (cnt == HW_W'(HW_PER_LINE - 1));
    end
endmodule

// File: rtl/lfs_lane_pack.sv
module lfs_lane_pack #(
    parameter  int BUS_W = 64,
    parameter  int HW_W  = 3,
    localparam int HALF  = BUS_W / 2
) (
    input  logic             wide,
    input  logic [HW_W-1:0]  word_idx,
    input  logic [BUS_W-1:0] beat,
    output logic [HW_W-2:0]  dword,
    output logic [1:0]       mask,
    output logic [BUS_W-1:0] data
);
    assign dword = word_idx[HW_W-1:1];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic hit;
        assign hit = (word_idx[0] == 1'(g));
        assign mask[g] = wide | hit;
        assign data[g*HALF +: HALF] = wide ? beat[g*HALF +: HALF]
                                    : (hit ? beat[HALF-1:0] : '0);
    end
endmodule

// File: rtl/lfs_line_fill.sv
module lfs_line_fill
    import lfs_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int LINE_BYTES = 32,
    parameter  int BUS_W      = 64,
    parameter  int WAYS       = 4,
    parameter  int SETS       = 128,
    localparam int BYTE_SH    = $clog2(BUS_W / 8),
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int HALF       = BUS_W / 2,
    localparam int HW_PER     = LINE_BYTES / (HALF / 8),
    localparam int HW_W       = $clog2(HW_PER),
    localparam int DW_W       = HW_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:BYTE_SH] req_addr,
    input  logic [WAY_W-1:0]        req_way,
    input  logic                    wide_mode,
    input  logic                    bus_valid,
    input  logic [BUS_W-1:0]        bus_data,
    output logic                    busy,
    output logic                    wr_en,
    output logic [WAY_W-1:0]        wr_way,
    output logic [IDX_W-1:0]        wr_index,
    output logic [DW_W-1:0]         wr_dword,
    output logic [1:0]              wr_mask,
    output logic [BUS_W-1:0]        wr_data,
    output logic                    fwd_valid,
    output logic [BUS_W-1:0]        fwd_data,
    output logic                    done,
    output logic                    tag_we,
    output logic [WAY_W-1:0]        tag_way,
    output logic [IDX_W-1:0]        tag_index,
    output logic [TAG_W-1:0]        tag_value
);
    typedef struct packed {
        lfs_state_e       state;
        logic [WAY_W-1:0] way;
        logic [IDX_W-1:0] index;
        logic [TAG_W-1:0] tag;
        logic             wide;
        logic [DW_W-1:0]  start_dw;
        logic [HW_W-1:0]  cnt;
        logic [HALF-1:0]  crit_lo;
        logic             wr_en;
        logic [DW_W-1:0]  wr_dword;
        logic [1:0]       wr_mask;
        logic [BUS_W-1:0] wr_data;
        logic             fwd_valid;
        logic [BUS_W-1:0] fwd_data;
        logic             done;
        logic             tag_we;
    } lfs_regs_t;

    lfs_regs_t r_d, r_q;

    logic [HW_W-1:0]  word_idx;
    logic             beat_last;
    logic [DW_W-1:0]  pk_dword;
    logic [1:0]       pk_mask;
    logic [BUS_W-1:0] pk_data;

    lfs_beat_order #(.HW_PER_LINE(HW_PER)) u_order (
        .wide     (r_q.wide),
        .start_dw (r_q.start_dw),
        .cnt      (r_q.cnt),
        .word_idx (word_idx),
        .last     (beat_last)
    );

    lfs_lane_pack #(.BUS_W(BUS_W), .HW_W(HW_W)) u_pack (
        .wide     (r_q.wide),
        .word_idx (word_idx),
        .beat     (bus_data),
        .dword    (pk_dword),
        .mask     (pk_mask),
        .data     (pk_data)
    );

    always_comb begin
        r_d           = r_q;
        r_d.wr_en     = 1'b0;
        r_d.fwd_valid = 1'b0;
        r_d.done      = 1'b0;
        r_d.tag_we    = 1'b0;
        unique case (r_q.state)
            LFS_IDLE: begin
                // the done cycle still counts as busy, so a request there waits
                if (req_valid && !r_q.done) begin
                    r_d.state    = LFS_FILL;
                    r_d.way      = req_way;
                    r_d.index    = req_addr[OFF_W+IDX_W-1:OFF_W];
                    r_d.tag      = req_addr[ADDR_W-1:OFF_W+IDX_W];
                    r_d.start_dw = req_addr[OFF_W-1:BYTE_SH];
                    r_d.wide     = wide_mode;
                    r_d.cnt      = '0;
                end
            end
            LFS_FILL: begin
                if (bus_valid) begin
                    r_d.wr_en    = 1'b1;
                    r_d.wr_dword = pk_dword;
                    r_d.wr_mask  = pk_mask;
                    r_d.wr_data  = pk_data;
                    if (r_q.cnt == '0) begin
                        r_d.crit_lo = bus_data[HALF-1:0];
                    end
                    if (r_q.wide && r_q.cnt == '0) begin
                        r_d.fwd_valid = 1'b1;
                        r_d.fwd_data  = bus_data;
                    end else if (!r_q.wide && r_q.cnt == HW_W'(1)) begin
                        r_d.fwd_valid = 1'b1;
                        r_d.fwd_data  = {bus_data[HALF-1:0], r_q.crit_lo};
                    end
                    if (beat_last) begin
                        r_d.state = LFS_FINISH;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            LFS_FINISH: begin
                r_d.done   = 1'b1;
                r_d.tag_we = 1'b1;
                r_d.state  = LFS_IDLE;
            end
            default: r_d.state = LFS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != LFS_IDLE) || r_q.done;
    assign wr_en     = r_q.wr_en;
    assign wr_way    = r_q.way;
    assign wr_index  = r_q.index;
    assign wr_dword  = r_q.wr_dword;
    assign wr_mask   = r_q.wr_mask;
    assign wr_data   = r_q.wr_data;
    assign fwd_valid = r_q.fwd_valid;
    assign fwd_data  = r_q.fwd_data;
    assign done      = r_q.done;
    assign tag_we    = r_q.tag_we;
    assign tag_way   = r_q.way;
    assign tag_index = r_q.index;
    assign tag_value = r_q.tag;
endmodule

// File: rtl/lfs_line_fill_chk.sv
module lfs_line_fill_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       bus_valid,
    input logic       busy,
    input logic       wr_en,
    input logic [1:0] wr_mask,
    input logic       fwd_valid,
    input logic       done,
    input logic       tag_we
);
    a_r6_write_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(bus_valid));

    a_r7_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    a_r7_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tag_we && $past(wr_en) && busy));

    a_r4_fwd_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> wr_en);

    a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_mask) != 0));
endmodule

bind lfs_line_fill lfs_line_fill_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bus_valid (bus_valid),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .fwd_valid (fwd_valid),
    .done      (done),
    .tag_we    (tag_we)
);

// File: tb/lfs_line_fill_tb.sv
module lfs_line_fill_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:3] req_addr = '0;
    logic [1:0]  req_way = '0;
    logic        wide_mode = 1'b1;
    logic        bus_valid = 1'b0;
    logic [63:0] bus_data = '0;
    logic        busy, wr_en, fwd_valid, done, tag_we;
    logic [1:0]  wr_way, wr_mask, wr_dword, tag_way;
    logic [6:0]  wr_index, tag_index;
    logic [63:0] wr_data, fwd_data;
    logic [19:0] tag_value;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    string cur = "R2";

    lfs_line_fill u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_way(req_way), .wide_mode(wide_mode), .bus_valid(bus_valid),
        .bus_data(bus_data), .busy(busy), .wr_en(wr_en), .wr_way(wr_way),
        .wr_index(wr_index), .wr_dword(wr_dword), .wr_mask(wr_mask),
        .wr_data(wr_data), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .done(done), .tag_we(tag_we), .tag_way(tag_way), .tag_index(tag_index),
        .tag_value(tag_value)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int          m_phase = 0;
    int          m_order[$];
    bit          m_wide;
    int          m_beat;
    logic [31:0] m_lo;
    logic [1:0]  m_way;
    logic [6:0]  m_idx;
    logic [19:0] m_tag;
    logic        e_wr = 0, e_fwd = 0, e_done = 0;
    logic [1:0]  e_dw, e_mask;
    logic [63:0] e_data, e_fdata;

    always @(posedge clk) begin
        e_wr   <= 1'b0;
        e_fwd  <= 1'b0;
        e_done <= 1'b0;
        if (!rst_n) begin
            m_phase = 0;
            m_order.delete();
        end else begin
            case (m_phase)
                0: if (req_valid && !e_done) begin
                    int s;
                    s = int'(req_addr[4:3]);
                    m_wide = wide_mode;
                    m_way = req_way;
                    m_idx = req_addr[11:5];
                    m_tag = req_addr[31:12];
                    m_order.delete();
                    if (m_wide) for (int k = 0; k < 4; k++) m_order.push_back(((s + k) % 4) * 2);
                    else for (int k = 0; k < 8; k++) m_order.push_back((2 * s + k) % 8);
                    m_beat = 0;
                    m_phase = 1;
                end
                1: if (bus_valid) begin
                    int w;
                    w = m_order.pop_front();
                    e_wr <= 1'b1;
                    e_dw <= 2'(w / 2);
                    if (m_wide) begin
                        e_mask <= 2'b11;
                        e_data <= bus_data;
                        if (m_beat == 0) begin e_fwd <= 1'b1; e_fdata <= bus_data; end
                    end else begin
                        e_mask <= (w % 2 == 1) ? 2'b10 : 2'b01;
                        e_data <= (w % 2 == 1) ? {bus_data[31:0], 32'h0} : {32'h0, bus_data[31:0]};
                        if (m_beat == 1) begin e_fwd <= 1'b1; e_fdata <= {bus_data[31:0], m_lo}; end
                    end
                    if (m_beat == 0) m_lo = bus_data[31:0];
                    m_beat++;
                    if (m_order.size() == 0) m_phase = 2;
                end
                default: begin
                    e_done <= 1'b1;
                    m_phase = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%h expected=%h", tag, cur, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7 busy", 64'(busy), 64'((m_phase != 0) || e_done));
            chk("R6 wr_en", 64'(wr_en), 64'(e_wr));
            chk("R8 done", 64'(done), 64'(e_done));
            chk("R8 tag_we", 64'(tag_we), 64'(e_done));
            chk(m_wide ? "R4 fwd_valid" : "R5 fwd_valid", 64'(fwd_valid), 64'(e_fwd));
            if (e_wr) begin
                chk(m_wide ? "R2 dword" : "R3 dword", 64'(wr_dword), 64'(e_dw));
                chk(m_wide ? "R2 mask" : "R3 mask", 64'(wr_mask), 64'(e_mask));
                chk(m_wide ? "R2 data" : "R3 data", wr_data, e_data);
                chk("R10 way", 64'(wr_way), 64'(m_way));
                chk("R10 index", 64'(wr_index), 64'(m_idx));
            end
            if (e_fwd) chk(m_wide ? "R4 fwd_data" : "R5 fwd_data", fwd_data, e_fdata);
            if (e_done) begin
                chk("R8 tag_way", 64'(tag_way), 64'(m_way));
                chk("R8 tag_index", 64'(tag_index), 64'(m_idx));
                chk("R8 tag_value", 64'(tag_value), 64'(m_tag));
            end
        end
    end

    task automatic fill(input logic [31:0] addr, input logic [1:0] way, input bit wide,
                        input int gap, input bit flip, input bit poke);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr[31:3];
        req_way   = way;
        wide_mode = wide;
        @(negedge clk);
        req_valid = poke;
        if (poke) begin req_addr = ~addr[31:3]; req_way = ~way; end
        if (flip) wide_mode = !wide;
        for (int b = 0; b < (wide ? 4 : 8); b++) begin
            if (gap != 0 && b % gap == 1) begin
                bus_valid = 1'b0;
                bus_data  = 64'hDEAD_BEEF_DEAD_BEEF;
                @(negedge clk);
            end
            bus_valid = 1'b1;
            bus_data  = {addr, 32'h0} ^ (64'(b + 1) * 64'h0123_4567_89AB_CDEF);
            @(negedge clk);
        end
        bus_valid = 1'b0;
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur = "R1";
        chk("R1 busy", 64'(busy), 64'h0);
        chk("R1 wr_en", 64'(wr_en), 64'h0);
        chk("R1 fwd_valid", 64'(fwd_valid), 64'h0);
        chk("R1 done", 64'(done), 64'h0);
        chk("R1 tag_we", 64'(tag_we), 64'h0);
        cmp_on = 1'b1;
        cur = "R2";  fill(32'h1234_5600, 2'd1, 1'b1, 0, 1'b0, 1'b0);
        cur = "R6";  fill(32'hABCD_EF50, 2'd3, 1'b1, 2, 1'b0, 1'b0);
        cur = "R3";  fill(32'h0000_0FE0, 2'd0, 1'b0, 0, 1'b0, 1'b0);
        cur = "R7";  fill(32'h8765_4378, 2'd2, 1'b0, 3, 1'b0, 1'b1);
        cur = "R9";  fill(32'h5555_AAA8, 2'd1, 1'b1, 0, 1'b1, 1'b0);
        cur = "R9";  fill(32'h2468_1350, 2'd2, 1'b0, 2, 1'b1, 1'b1);
        cur = "R10"; fill(32'hFFFF_FFF0, 2'd3, 1'b1, 1, 1'b0, 1'b1);
        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule